// File: doc/BRIEF.md
# Key-Protected EEPROM Block Programmer

This controller guards and sequences block programming of an on-chip data EEPROM. Software uses a small register bus to fill a row of sixteen word latches, load a block-program command, give a two-word unlock key and then raise a start bit. If every guard condition holds at that moment, the controller stays busy for a fixed number of cycles. It then copies the whole latch row into a modelled storage array in one step and pulses a completion flag. Each stored word is simply replaced, which stands in for erase followed by write.

Several guards stand between software and the array. The write-enable bit clears at reset. A power-up timer blocks any start until it has expired. The unlock tracker requires the two key words to arrive back to back and directly before the start write. A start that fails any guard does not program. It sets a sticky error flag that software clears by writing zero to it.

Top module: `eeblk_ctrl`

## Requirements
- R1: After reset the control register reads 0x0000 (start, write-enable and error bits all zero), the address register reads 0, and `prog_busy` and `prog_done` are low.
- R2: A bus write with select 3 stores the data in latch `bus_addr[3:0]` and loads the whole `bus_addr` into the address register (select 1). The latch can be read back through select 3, and the address register always holds the address of the most recent accepted latch write.
- R3: The control register (select 0) holds the start bit at bit 15, write-enable at bit 14, the error flag at bit 13 and the operation code in bits 3:0. Writing 0x400A while idle makes the register read back 0x400A.
- R4: A start is accepted only if the key register (select 2) received 0x0055 and then 0x00AA, and the very next bus write is the control write carrying the start bit. Any other bus write in between, to any register, cancels the unlock.
- R5: A start also needs write-enable (bit 14) and operation code 0xA in the written control word, and all sixteen latches written since the last completed program.
- R6: No start is accepted until PWRUP_CYCLES clock edges have passed since reset release.
- R7: After an accepted start, `prog_busy` and control bit 15 are high for exactly BUSY_CYCLES cycles, starting in the cycle after the start write. `prog_done` is then high for one cycle. Control writes during the busy period are ignored.
- R8: At completion, latch i is copied into array word row*16+i, where row is address-register bits [ADDR_W-1:4]. Array words can be read through select 4 at that address. Other rows keep their contents, and unprogrammed words read 0xFFFF.
- R9: Latch writes made while busy change neither the latches nor the address register.
- R10: A start request that is refused sets control bit 13. The bit stays set until a control write with bit 13 at zero clears it. Writing a one to it has no effect.
- R11: After completion every latch reads 0xFFFF and the fill record is empty, so a repeated start without a refill is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_sel | input | 3 | Register select: 0 control, 1 address, 2 key, 3 latch, 4 array |
| bus_addr | input | ADDR_W | Word address for latch writes and latch/array reads |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for the current select and address |
| prog_busy | output | 1 | High while a block program is in progress |
| prog_done | output | 1 | One-cycle pulse after the row is committed |

## Verification
Reads are combinational, so a read result is due in the same cycle its select and address are applied. A register write shows up in the cycle after its strobe. Busy rises in the cycle after the accepted start write and stays high for BUSY_CYCLES cycles; the done pulse and the committed row appear in the next cycle. The driver applies one operation per cycle just after the rising edge and queues the expected value for that same cycle. The monitor compares at the falling edge, so each expectation is tied to a fixed cycle offset from its stimulus.

// File: rtl/eeblk_pkg.sv
package eeblk_pkg;
  localparam int WORD_W  = 16;
  localparam int LATCHES = 16;
  localparam int LIDX_W  = $clog2(LATCHES);

  typedef enum logic [2:0] {
    SEL_CTRL  = 3'd0,
    SEL_ADDR  = 3'd1,
    SEL_KEY   = 3'd2,
    SEL_LATCH = 3'd3,
    SEL_ARRAY = 3'd4
  } sel_e;

  typedef enum logic [1:0] {
    UL_IDLE  = 2'd0,
    UL_HALF  = 2'd1,
    UL_ARMED = 2'd2
  } unlock_e;

  localparam logic [WORD_W-1:0] KEY_FIRST  = 16'h0055;
  localparam logic [WORD_W-1:0] KEY_SECOND = 16'h00AA;
  localparam logic [3:0]        OP_BLOCK   = 4'hA;

  localparam int CTL_GO  = 15;
  localparam int CTL_WEN = 14;
  localparam int CTL_ERR = 13;

  // written control word asks for a block program with write-enable set
  function automatic logic cmd_is_block(input logic [WORD_W-1:0] w);
    return w[CTL_WEN] && (w[3:0] == OP_BLOCK);
  endfunction

  function automatic logic [WORD_W-1:0] pack_ctrl(input logic go, input logic wen,
                                                  input logic err, input logic [3:0] op);
    logic [WORD_W-1:0] v;
    v          = '0;
    v[CTL_GO]  = go;
    v[CTL_WEN] = wen;
    v[CTL_ERR] = err;
    v[3:0]     = op;
    return v;
  endfunction
endpackage

// File: rtl/eeblk_unlock.sv
module eeblk_unlock
  import eeblk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  sel_e              sel,
  input  logic [WORD_W-1:0] wdata,
  output logic              armed
);
  unlock_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (wr) begin
      if (sel == SEL_KEY) begin
        if (wdata == KEY_FIRST)                             state_d = UL_HALF;
        else if (state_q == UL_HALF && wdata == KEY_SECOND) state_d = UL_ARMED;
        else                                                state_d = UL_IDLE;
      end else begin
        // any non-key write (including the start write itself) consumes the unlock
        state_d = UL_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= UL_IDLE;
    else        state_q <= state_d;
  end

  assign armed = (state_q == UL_ARMED);
endmodule

// File: rtl/eeblk_latch_row.sv
module eeblk_latch_row #(
  parameter int LATCHES = 16,
  parameter int WORD_W  = 16,
  localparam int LIDX_W = $clog2(LATCHES)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            we,
  input  logic [LIDX_W-1:0]               widx,
  input  logic [WORD_W-1:0]               wdata,
  input  logic                            clear,
  input  logic [LIDX_W-1:0]               rd_idx,
  output logic [WORD_W-1:0]               rd_data,
  output logic [LATCHES-1:0][WORD_W-1:0]  row_data,
  output logic                            full,
  output logic                            any
);
  logic [LATCHES-1:0] fill_q;

  for (genvar i = 0; i < LATCHES; i++) begin : g_lat
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q    <= '1;
        fill_q[i] <= 1'b0;
      end else if (clear) begin
        word_q    <= '1;
        fill_q[i] <= 1'b0;
      end else if (we && widx == LIDX_W'(i)) begin
        word_q    <= wdata;
        fill_q[i] <= 1'b1;
      end
    end
    assign row_data[i] = word_q;
  end

  assign rd_data = row_data[rd_idx];
  assign full    = &fill_q;
  assign any     = |fill_q;
endmodule

// File: rtl/eeblk_prog_seq.sv
module eeblk_prog_seq #(
  parameter int PWRUP_CYCLES = 64,
  parameter int BUSY_CYCLES  = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic pwrup_ready,
  output logic busy,
  output logic commit,
  output logic done
);
  localparam int PW_W = $clog2(PWRUP_CYCLES + 1);
  localparam int BC_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [PW_W-1:0] P_END  = PW_W'(PWRUP_CYCLES);
  localparam logic [BC_W-1:0] B_LAST = BC_W'(BUSY_CYCLES - 1);

  logic [PW_W-1:0] pcnt_q;
  logic [BC_W-1:0] bcnt_q;

  assign pwrup_ready = (pcnt_q == P_END);
  assign commit      = busy && (bcnt_q == B_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            pcnt_q <= '0;
    else if (!pwrup_ready) pcnt_q <= pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      bcnt_q <= '0;
      done   <= 1'b0;
    end else begin
      done <= commit;
      if (busy) begin
        if (commit) busy   <= 1'b0;
        else        bcnt_q <= bcnt_q + 1'b1;
      end else if (start) begin
        busy   <= 1'b1;
        bcnt_q <= '0;
      end
    end
  end
endmodule

// File: rtl/eeblk_array.sv
module eeblk_array #(
  parameter int ROWS    = 8,
  parameter int LATCHES = 16,
  parameter int WORD_W  = 16,
  localparam int ROW_W  = $clog2(ROWS),
  localparam int LIDX_W = $clog2(LATCHES)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           commit,
  input  logic [ROW_W-1:0]               row,
  input  logic [LATCHES-1:0][WORD_W-1:0] row_data,
  input  logic [ROW_W-1:0]               rd_row,
  input  logic [LIDX_W-1:0]              rd_col,
  output logic [WORD_W-1:0]              rd_data
);
  logic [LATCHES-1:0][WORD_W-1:0] rows_view [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [LATCHES-1:0][WORD_W-1:0] cells_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              cells_q <= '1;
      else if (commit && row == ROW_W'(r))     cells_q <= row_data;
    end
    assign rows_view[r] = cells_q;
  end

  assign rd_data = rows_view[rd_row][rd_col];
endmodule

// File: rtl/eeblk_ctrl.sv
module eeblk_ctrl
  import eeblk_pkg::*;
#(
  parameter int ROWS         = 8,
  parameter int BUSY_CYCLES  = 32,
  parameter int PWRUP_CYCLES = 64,
  localparam int ROW_W  = $clog2(ROWS),
  localparam int ADDR_W = ROW_W + LIDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [2:0]        bus_sel,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              prog_busy,
  output logic              prog_done
);
  sel_e sel;
  assign sel = sel_e'(bus_sel);

  // named internal events for the checker
  logic              unlock_armed;
  logic              pwrup_ready;
  logic              fill_full;
  logic              fill_any;
  logic              commit;
  logic              ctrl_we;
  logic              lat_we;
  logic              start_req;
  logic              start_ok;
  logic              start_accept;
  logic              start_reject;
  logic              wen_q;
  logic              err_q;
  logic [3:0]        op_q;
  logic [ADDR_W-1:0] addr_q;

  logic [LATCHES-1:0][WORD_W-1:0] row_data;
  logic [WORD_W-1:0]              lat_rd;
  logic [WORD_W-1:0]              arr_rd;

  assign ctrl_we      = bus_wr && (sel == SEL_CTRL) && !prog_busy;
  assign lat_we       = bus_wr && (sel == SEL_LATCH) && !prog_busy;
  assign start_req    = ctrl_we && bus_wdata[CTL_GO];
  assign start_ok     = unlock_armed && cmd_is_block(bus_wdata) && fill_full && pwrup_ready;
  assign start_accept = start_req && start_ok;
  assign start_reject = start_req && !start_ok;

  eeblk_unlock u_unlock (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (bus_wr),
    .sel   (sel),
    .wdata (bus_wdata),
    .armed (unlock_armed)
  );

  eeblk_latch_row #(.LATCHES(LATCHES), .WORD_W(WORD_W)) u_latches (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (lat_we),
    .widx     (bus_addr[LIDX_W-1:0]),
    .wdata    (bus_wdata),
    .clear    (commit),
    .rd_idx   (bus_addr[LIDX_W-1:0]),
    .rd_data  (lat_rd),
    .row_data (row_data),
    .full     (fill_full),
    .any      (fill_any)
  );

  eeblk_prog_seq #(.PWRUP_CYCLES(PWRUP_CYCLES), .BUSY_CYCLES(BUSY_CYCLES)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start_accept),
    .pwrup_ready (pwrup_ready),
    .busy        (prog_busy),
    .commit      (commit),
    .done        (prog_done)
  );

  eeblk_array #(.ROWS(ROWS), .LATCHES(LATCHES), .WORD_W(WORD_W)) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit   (commit),
    .row      (addr_q[ADDR_W-1:LIDX_W]),
    .row_data (row_data),
    .rd_row   (bus_addr[ADDR_W-1:LIDX_W]),
    .rd_col   (bus_addr[LIDX_W-1:0]),
    .rd_data  (arr_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wen_q  <= 1'b0;
      err_q  <= 1'b0;
      op_q   <= '0;
      addr_q <= '0;
    end else begin
      if (lat_we) addr_q <= bus_addr;
      if (ctrl_we) begin
        wen_q <= bus_wdata[CTL_WEN];
        op_q  <= bus_wdata[3:0];
        if (start_reject)            err_q <= 1'b1;
        else if (!bus_wdata[CTL_ERR]) err_q <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (sel)
      SEL_CTRL:  bus_rdata = pack_ctrl(prog_busy, wen_q, err_q, op_q);
      SEL_ADDR:  bus_rdata = WORD_W'(addr_q);
      SEL_LATCH: bus_rdata = lat_rd;
      SEL_ARRAY: bus_rdata = arr_rd;
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/eeblk_ctrl_chk.sv
module eeblk_ctrl_chk #(
  parameter int BUSY_CYCLES = 32
) (
  input logic clk,
  input logic rst_n,
  input logic unlock_armed,
  input logic pwrup_ready,
  input logic fill_full,
  input logic fill_any,
  input logic start_reject,
  input logic err_q,
  input logic prog_busy,
  input logic prog_done
);
  localparam int RL_W = $clog2(BUSY_CYCLES + 2);
  logic [RL_W-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run_len <= '0;
    else if (prog_busy) run_len <= run_len + 1'b1;
    else                run_len <= '0;
  end

  AST_START_NEEDS_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_busy) |-> $past(unlock_armed)); // R4
  AST_START_NEEDS_FULL_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_busy) |-> $past(fill_full)); // R5
  AST_START_AFTER_PWRUP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_busy) |-> $past(pwrup_ready)); // R6
  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prog_busy) |-> (run_len == RL_W'(BUSY_CYCLES))); // R7
  AST_DONE_FOLLOWS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |-> (!prog_busy && $past(prog_busy))); // R7
  AST_LATCHES_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |-> !fill_any); // R11
  AST_REJECT_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    start_reject |=> err_q); // R10
endmodule

bind eeblk_ctrl eeblk_ctrl_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .unlock_armed (unlock_armed),
  .pwrup_ready  (pwrup_ready),
  .fill_full    (fill_full),
  .fill_any     (fill_any),
  .start_reject (start_reject),
  .err_q        (err_q),
  .prog_busy    (prog_busy),
  .prog_done    (prog_done)
);

// File: tb/eeblk_ctrl_tb.sv
module eeblk_ctrl_tb;
  localparam int ROWS  = 8;
  localparam int AW    = 7;
  localparam int PWRUP = 64;
  localparam int BUSY  = 32;
  localparam logic [2:0] S_CTRL = 3'd0, S_ADDR = 3'd1, S_KEY = 3'd2,
                         S_LAT = 3'd3, S_ARR = 3'd4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_wr;
  logic [2:0]    bus_sel;
  logic [AW-1:0] bus_addr;
  logic [15:0]   bus_wdata;
  logic [15:0]   bus_rdata;
  logic          prog_busy;
  logic          prog_done;

  always #4 clk = ~clk;

  eeblk_ctrl #(.ROWS(ROWS), .BUSY_CYCLES(BUSY), .PWRUP_CYCLES(PWRUP)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .prog_busy(prog_busy), .prog_done(prog_done));

  typedef struct {
    logic        chk_rd;
    logic [15:0] exp_rd;
    logic [1:0]  exp_port;   // {done, busy}
    string       tag;
  } item_t;

  item_t       sb_q[$];
  int          checks = 0;
  int          fails  = 0;
  logic [15:0] lat_m [16];
  logic [15:0] mem_m [ROWS*16];

  // monitor: mid-cycle comparison of what the driver queued this cycle
  always @(negedge clk) begin
    item_t it;
    if (sb_q.size() > 0) begin
      it = sb_q.pop_front();
      checks++;
      if (it.chk_rd && bus_rdata !== it.exp_rd) begin
        fails++;
        $display("FAIL %s rdata actual=%h expected=%h", it.tag, bus_rdata, it.exp_rd);
      end else if ({prog_done, prog_busy} !== it.exp_port) begin
        fails++;
        $display("FAIL %s {done,busy} actual=%b expected=%b", it.tag,
                 {prog_done, prog_busy}, it.exp_port);
      end
    end
  end

  task automatic wr(input logic [2:0] s, input int a, input logic [15:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_sel = s; bus_addr = AW'(a); bus_wdata = d;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; bus_wr = 1'b0; end
  endtask

  task automatic expect_rd(input logic [2:0] s, input int a, input logic [15:0] e,
                           input logic [1:0] port, input string tag);
    item_t it;
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_sel = s; bus_addr = AW'(a);
    it.chk_rd = 1'b1; it.exp_rd = e; it.exp_port = port; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic key_start(input logic [15:0] cw);
    wr(S_KEY, 0, 16'h0055);
    wr(S_KEY, 0, 16'h00AA);
    wr(S_CTRL, 0, cw);
  endtask

  task automatic fill(input int row, input int count, input logic [15:0] base);
    for (int i = 0; i < count; i++) begin
      wr(S_LAT, row*16 + i, base + 16'(i*7));
      lat_m[i] = base + 16'(i*7);
    end
  endtask

  task automatic commit_model(input int row);
    for (int i = 0; i < 16; i++) begin
      mem_m[row*16 + i] = lat_m[i];
      lat_m[i] = 16'hFFFF;
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #(8*200000);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) lat_m[i] = 16'hFFFF;
    for (int i = 0; i < ROWS*16; i++) mem_m[i] = 16'hFFFF;
    rst_n = 1'b0; bus_wr = 1'b0; bus_sel = S_CTRL; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    expect_rd(S_CTRL, 0, 16'h0000, 2'b00, "R1 ctrl reset");
    expect_rd(S_ADDR, 0, 16'h0000, 2'b00, "R1 addr reset");

    fill(2, 16, 16'hA100);
    expect_rd(S_LAT, 2*16+5, lat_m[5], 2'b00, "R2 latch 5 readback");
    expect_rd(S_LAT, 2*16+15, lat_m[15], 2'b00, "R2 latch 15 readback");
    expect_rd(S_ADDR, 0, 16'h002F, 2'b00, "R2 address of last latch write");

    wr(S_CTRL, 0, 16'h400A);
    expect_rd(S_CTRL, 0, 16'h400A, 2'b00, "R3 command readback");

    // still inside the power-up window
    key_start(16'hC00A);
    expect_rd(S_CTRL, 0, 16'h600A, 2'b00, "R6 start blocked before power-up, R10 err set");
    wr(S_CTRL, 0, 16'h600A);
    expect_rd(S_CTRL, 0, 16'h600A, 2'b00, "R10 writing one keeps err");
    wr(S_CTRL, 0, 16'h400A);
    expect_rd(S_CTRL, 0, 16'h400A, 2'b00, "R10 writing zero clears err");

    idle(PWRUP);

    // foreign write between the keys
    wr(S_KEY, 0, 16'h0055);
    wr(S_ADDR, 0, 16'h0000);
    wr(S_KEY, 0, 16'h00AA);
    wr(S_CTRL, 0, 16'hC00A);
    expect_rd(S_CTRL, 0, 16'h600A, 2'b00, "R4 write between keys cancels unlock");
    wr(S_CTRL, 0, 16'h400A);
    // control write without start between key and start
    wr(S_KEY, 0, 16'h0055);
    wr(S_KEY, 0, 16'h00AA);
    wr(S_CTRL, 0, 16'h400A);
    wr(S_CTRL, 0, 16'hC00A);
    expect_rd(S_CTRL, 0, 16'h600A, 2'b00, "R4 write between key and start cancels unlock");
    wr(S_CTRL, 0, 16'h400A);
    // wrong operation code, then write-enable missing
    key_start(16'hC005);
    expect_rd(S_CTRL, 0, 16'h6005, 2'b00, "R5 wrong op code refused");
    wr(S_CTRL, 0, 16'h400A);
    key_start(16'h800A);
    expect_rd(S_CTRL, 0, 16'h200A, 2'b00, "R5 missing write-enable refused");
    wr(S_CTRL, 0, 16'h400A);
    expect_rd(S_ADDR, 0, 16'h002F, 2'b00, "R2 address unchanged by other writes");

    // accepted program of row 2, with a latch write in the first busy cycle
    key_start(16'hC00A);
    wr(S_LAT, 2*16+0, 16'h1234);
    for (int i = 1; i < BUSY; i++)
      expect_rd(S_CTRL, 0, 16'hC00A, 2'b01, "R7 busy with start bit set");
    expect_rd(S_CTRL, 0, 16'h400A, 2'b10, "R7 done pulse, start bit cleared");
    expect_rd(S_CTRL, 0, 16'h400A, 2'b00, "R7 done lasts one cycle");
    commit_model(2);
    expect_rd(S_ADDR, 0, 16'h002F, 2'b00, "R9 latch write while busy ignored");
    for (int i = 0; i < 16; i++)
      expect_rd(S_ARR, 2*16+i, mem_m[2*16+i], 2'b00, "R8 row 2 committed");
    expect_rd(S_ARR, 0, 16'hFFFF, 2'b00, "R8 untouched row erased");
    expect_rd(S_LAT, 2*16+0, 16'hFFFF, 2'b00, "R11 latch 0 restored");
    expect_rd(S_LAT, 2*16+9, 16'hFFFF, 2'b00, "R11 latch 9 restored");

    key_start(16'hC00A);
    expect_rd(S_CTRL, 0, 16'h600A, 2'b00, "R11 repeat start without refill refused");
    wr(S_CTRL, 0, 16'h400A);

    // partial fill of row 5
    fill(5, 15, 16'h5A00);
    key_start(16'hC00A);
    expect_rd(S_CTRL, 0, 16'h600A, 2'b00, "R5 fifteen latches refused");
    wr(S_LAT, 5*16+15, 16'h0F0F);
    lat_m[15] = 16'h0F0F;
    wr(S_CTRL, 0, 16'h400A);
    key_start(16'hC00A);
    for (int i = 0; i < BUSY; i++)
      expect_rd(S_CTRL, 0, 16'hC00A, 2'b01, "R7 second program busy");
    expect_rd(S_CTRL, 0, 16'h400A, 2'b10, "R7 second program done");
    commit_model(5);
    for (int i = 0; i < 16; i++)
      expect_rd(S_ARR, 5*16+i, mem_m[5*16+i], 2'b00, "R8 row 5 committed");
    expect_rd(S_ARR, 2*16+3, mem_m[2*16+3], 2'b00, "R8 row 2 kept");

    idle(3);
    summary();
    $finish;
  end
endmodule